// File: doc/BRIEF.md
# Chained Serial Command Receiver

This block is the receiving end of one device on a serial chain. Several such devices share one chip select and one serial clock. Each device's data output feeds the data input of the next device. Inside the block, a 16-bit shift register takes one bit from the serial input on each rising edge of the serial clock while select is low. The top bit of the register is driven onto the serial output on each falling edge, so a downstream device reads it on the next rising edge. Taken together, the chain acts like one long shift register. After sixteen clocks per device, each device holds its own 16-bit slice. The farthest device holds the earliest bits sent.

When select returns high, the block takes the register contents as one command. It presents the upper byte as an address and the lower byte as data, and strobes a valid flag for a single system clock cycle. A word of all zeros is a no-operation: no strobe is raised and the parallel outputs keep their previous values. The serial pins are sampled in the system clock domain through synchronizers. Edges of the serial clock and of select are detected there. Interpreting the address and data is left to the logic that follows.

Top module: `dchain_rx_reg`

## Requirements
- R1: After reset, `cmd_valid`, `cmd_addr`, `cmd_data` and `ser_out` are all 0.
- R2: While `sel_n` is low, each rising edge of `ser_clk` shifts `ser_in` into bit 0 of the 16-bit register. After 16 edges, the first bit sent sits in bit 15, so a word sent most significant bit first is received unchanged.
- R3: While `sel_n` is low, each falling edge of `ser_clk` sets `ser_out` to the register's current bit 15. This is the bit that leaves the register on the next rising edge.
- R4: Two devices chained output-to-input and clocked 32 times in one select window end with the downstream device holding the first 16 bits sent and the upstream device holding the last 16.
- R5: A rising edge of `sel_n` with a nonzero register raises `cmd_valid` for exactly one system clock cycle. At the same time it presents bits 15:8 on `cmd_addr` and bits 7:0 on `cmd_data`. No strobe occurs while bits are being shifted.
- R6: A rising edge of `sel_n` with an all-zero register raises no strobe, and `cmd_addr`/`cmd_data` keep their prior values.
- R7: While `sel_n` is high, `ser_clk` edges change neither the register nor `ser_out`. A later select window with no clocks re-commits the held word.
- R8: When more than 16 bits are sent in one window, only the last 16 remain in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Shared serial clock of the chain |
| sel_n | input | 1 | Shared active-low select; its rising edge commits the word |
| ser_in | input | 1 | Serial data from the controller or the upstream device |
| ser_out | output | 1 | Serial data toward the downstream device |
| cmd_valid | output | 1 | One-cycle strobe for a committed nonzero word |
| cmd_addr | output | 8 | Upper byte of the committed word |
| cmd_data | output | 8 | Lower byte of the committed word |

## Verification
On every cycle, the assertions check the following:
- each enabled rising edge shifts the register by one place;
- each enabled falling edge copies the top bit to the output;
- a deselected window leaves the register and the output frozen;
- every strobe is one cycle long, follows a select rise, and carries a nonzero word;
- a zero word never strobes or changes the outputs.

Some properties can only be shown by the bench's scenarios. These are the bit order of whole words, the slicing of a 32-bit stream across two chained devices, the loss of the oldest bits on overflow, and the re-commit of a held word after ignored clocks.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned WORD_W = ADDR_W + DATA_W;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dchain_rst_sync.sv
module dchain_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/dchain_front.sv
module dchain_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic ser_clk,
  input  logic sel_n,
  input  logic ser_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sel_rise,
  output logic sel_act,
  output logic din_s
);
  localparam int unsigned LAST = SYNC_STAGES - 1;
  localparam logic [2:0] PIN_IDLE = 3'b010;   // {ser_clk, sel_n, ser_in}

  logic [SYNC_STAGES-1:0][2:0] stg_q;
  logic                        sclk_q, sel_q;
  logic                        sclk_s, sel_s;

  // synchronizer chain, all three pins aligned
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) stg_q <= {SYNC_STAGES{PIN_IDLE}};
    else         stg_q <= {stg_q[SYNC_STAGES-2:0], {ser_clk, sel_n, ser_in}};
  end

  assign sclk_s = stg_q[LAST][2];
  assign sel_s  = stg_q[LAST][1];
  assign din_s  = stg_q[LAST][0];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      sel_q  <= sel_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign sel_rise  = sel_s & ~sel_q;
  assign sel_act   = ~sel_s;
endmodule

// File: rtl/dchain_shifter.sv
module dchain_shifter
  import dchain_pkg::*;
(
  input  logic  clk,
  input  logic  rst_sn,
  input  logic  sclk_rise,
  input  logic  sclk_fall,
  input  logic  sel_act,
  input  logic  din_s,
  output word_t shreg,
  output logic  ser_out
);
  word_t shreg_q, shreg_d;
  logic  out_q, out_d;
  logic  shift_en, drive_en;

  assign shift_en = sclk_rise & sel_act;
  assign drive_en = sclk_fall & sel_act;

  always_comb begin
    shreg_d = shreg_q;
    out_d   = out_q;
    if (shift_en) shreg_d = {shreg_q[WORD_W-2:0], din_s};
    if (drive_en) out_d   = shreg_q[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      shreg_q <= '0;
      out_q   <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      out_q   <= out_d;
    end
  end

  assign shreg   = shreg_q;
  assign ser_out = out_q;

  AST_SHIFT_ONE_PLACE: assert property (@(posedge clk) disable iff (!rst_sn)
    (sclk_rise && sel_act) |=> (shreg_q == {$past(shreg_q[WORD_W-2:0]), $past(din_s)})); // R2
  AST_OUT_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_sn)
    (sclk_fall && sel_act) |=> (ser_out == $past(shreg_q[WORD_W-1]))); // R3
  AST_FROZEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_sn)
    !sel_act |=> ($stable(shreg_q) && $stable(ser_out))); // R7
endmodule

// File: rtl/dchain_commit.sv
module dchain_commit
  import dchain_pkg::*;
(
  input  logic  clk,
  input  logic  rst_sn,
  input  logic  sel_rise,
  input  word_t shreg,
  output logic  cmd_valid,
  output word_t cmd_word
);
  logic  valid_q, valid_d;
  word_t word_q, word_d;
  logic  load_en;

  assign load_en = sel_rise & (shreg != '0);

  always_comb begin
    valid_d = load_en;
    word_d  = word_q;
    if (load_en) word_d = shreg;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= valid_d;
      word_q  <= word_d;
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_word  = word_q;

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid |=> !cmd_valid); // R5
  AST_STROBE_AFTER_SEL_RISE: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid |-> $past(sel_rise)); // R5
  AST_STROBE_NONZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid |-> (cmd_word != '0)); // R6
  AST_ZERO_IS_NOP: assert property (@(posedge clk) disable iff (!rst_sn)
    (sel_rise && shreg == '0) |=> (!cmd_valid && $stable(cmd_word))); // R6
endmodule

// File: rtl/dchain_rx_reg.sv
module dchain_rx_reg
  import dchain_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              sel_n,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  logic  rst_sn;
  logic  sclk_rise, sclk_fall, sel_rise, sel_act, din_s;
  word_t shreg, cmd_word;

  dchain_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  dchain_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_sn(rst_sn),
    .ser_clk(ser_clk), .sel_n(sel_n), .ser_in(ser_in),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sel_rise(sel_rise), .sel_act(sel_act), .din_s(din_s)
  );

  dchain_shifter u_shift (
    .clk(clk), .rst_sn(rst_sn),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .sel_act(sel_act), .din_s(din_s),
    .shreg(shreg), .ser_out(ser_out)
  );

  dchain_commit u_commit (
    .clk(clk), .rst_sn(rst_sn),
    .sel_rise(sel_rise), .shreg(shreg),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word)
  );

  assign cmd_addr = cmd_word[WORD_W-1 -: ADDR_W];
  assign cmd_data = cmd_word[DATA_W-1:0];

  AST_ADDR_DATA_SPLIT: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_valid |-> ({cmd_addr, cmd_data} == $past(shreg))); // R5
endmodule

// File: tb/test_dchain_rx_reg.sv
module test_dchain_rx_reg;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, sel_n = 1'b1, ser_in = 1'b0;
  logic near_out, far_out, near_valid, far_valid;
  logic [7:0] near_addr, near_data, far_addr, far_data;

  int n_chk = 0, n_bad = 0;
  int near_pulses = 0, far_pulses = 0;
  bit done = 0;
  logic [15:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dchain_rx_reg i_dchain_rx_reg (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sel_n(sel_n), .ser_in(ser_in),
    .ser_out(near_out), .cmd_valid(near_valid), .cmd_addr(near_addr), .cmd_data(near_data)
  );

  dchain_rx_reg i_dchain_rx_reg_far (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sel_n(sel_n), .ser_in(near_out),
    .ser_out(far_out), .cmd_valid(far_valid), .cmd_addr(far_addr), .cmd_data(far_data)
  );

  always @(negedge clk) begin
    if (near_valid) near_pulses++;
    if (far_valid)  far_pulses++;
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_in = b;
    wait_clk(HB);
    ser_clk = 1'b1;
    if (!sel_n) model = {model[14:0], b};
    wait_clk(HB);
    ser_clk = 1'b0;
    wait_clk(HB);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic frame_begin();
    sel_n = 1'b0;
    wait_clk(HB);
  endtask

  task automatic frame_end();
    sel_n = 1'b1;
    wait_clk(2*HB);
  endtask

  task automatic t_reset();
    check(near_valid, 0, "R1 cmd_valid");
    check(near_addr, 0, "R1 cmd_addr");
    check(near_data, 0, "R1 cmd_data");
    check(near_out, 0, "R1 ser_out");
  endtask

  task automatic t_basic(input logic [15:0] w);
    int base = near_pulses;
    frame_begin();
    send_word(w);
    check(near_pulses - base, 0, "R5 no strobe while shifting");
    frame_end();
    check(near_pulses - base, 1, "R5 single strobe");
    check({near_addr, near_data}, w, "R2 R5 committed word");
  endtask

  task automatic t_zero();
    int base = near_pulses;
    logic [15:0] prev = {near_addr, near_data};
    frame_begin();
    send_word(16'h0000);
    frame_end();
    check(near_pulses - base, 0, "R6 zero word strobe");
    check({near_addr, near_data}, prev, "R6 outputs held");
  endtask

  task automatic t_overflow();
    int base = near_pulses;
    frame_begin();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    send_word(16'h5AC3);
    frame_end();
    check(near_pulses - base, 1, "R8 strobe after overflow");
    check({near_addr, near_data}, 16'h5AC3, "R8 last 16 bits kept");
  endtask

  task automatic t_dout(input logic [15:0] w);
    frame_begin();
    for (int i = 15; i >= 0; i--) begin
      send_bit(w[i]);
      check(near_out, model[15], "R3 ser_out after falling edge");
    end
    frame_end();
  endtask

  task automatic t_hold();
    int base = near_pulses;
    logic [15:0] held = {near_addr, near_data};
    logic o = near_out;
    ser_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ser_clk = 1'b1; wait_clk(HB);
      ser_clk = 1'b0; wait_clk(HB);
    end
    check(near_out, o, "R7 ser_out frozen when deselected");
    check(near_pulses - base, 0, "R7 no strobe when deselected");
    frame_begin();
    frame_end();
    check(near_pulses - base, 1, "R7 re-commit strobe");
    check({near_addr, near_data}, held, "R7 held word re-committed");
  endtask

  task automatic t_chain(input logic [15:0] first_w, input logic [15:0] last_w);
    int nb = near_pulses, fb = far_pulses;
    frame_begin();
    send_word(first_w);
    send_word(last_w);
    frame_end();
    check(near_pulses - nb, 1, "R4 upstream strobe");
    check(far_pulses - fb, 1, "R4 downstream strobe");
    check({near_addr, near_data}, last_w, "R4 upstream holds last slice");
    check({far_addr, far_data}, first_w, "R4 downstream holds first slice");
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    t_reset();
    t_basic(16'hA35C);
    t_basic(16'h0F01);
    t_zero();
    t_overflow();
    t_dout(16'h9E27);
    t_hold();
    t_chain(16'hBEEF, 16'h7A01);
    report();
  end
endmodule